// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small 32-bit processor core that runs a load/store subset of seven operations: register add, subtract, AND and OR, word load, word store, and branch-if-equal. Each instruction passes through five stages in order: fetch, decode, execute, memory access and write-back. A pipeline register sits between each pair of neighbouring stages. The program counter and all four pipeline registers load on every clock edge. Up to five instructions are in flight, and in steady state one instruction retires per cycle.

The instruction memory and the data memory are outside the core. The core drives a fetch address and receives the fetched word in the same cycle. It drives a data address, store data and read/write strobes from its memory stage and receives load data in that same cycle. Control is decoded once, in decode. It travels with the instruction in three groups (execute, memory, write-back), and each group is dropped after the stage that uses it. There is no hazard detection, forwarding, stalling or flushing. Programs must keep dependent instructions apart, padding with all-zero words (no-ops) where needed. The write-back stage is visible on three output ports.

Top module: `pipe5_core`

## Requirements
- R1: While reset is high and in the cycle after it falls, the fetch address equals START_ADDR. All control fields are cleared, so dmem_we, dmem_re and wb_we stay low until a real instruction reaches the memory or write-back stage.
- R2: Each cycle the fetch address advances by 4, unless a taken branch is in the memory stage. In that case the next fetch address is that branch's target.
- R3: An instruction fetched in cycle n shows its write-back on wb_we/wb_reg/wb_data in cycle n+4, one instruction per cycle. With every register preset to index+100 and every data word to 99, the sequence load r8,4(r29); sub r2,r4,r5; and r9,r10,r11; or r16,r17,r18; add r13,r14,r0, fetched from cycle 1, writes back 99, -1, 110, 119 and 114 in cycles 5 to 9.
- R4: Opcode 0x00 (bits 31:26) selects a register operation on rs (25:21) and rt (20:16), written to rd (15:11). The funct field (5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR.
- R5: Opcode 0x23 loads the word at rs + sign-extended bits 15:0 into rt. dmem_re is high in the memory stage (fetch + 3), and dmem_rdata is taken in that same cycle.
- R6: Opcode 0x2B stores rt to rs + sign-extended imm. In the memory stage (fetch + 3), dmem_we is high with that address and data.
- R7: Opcode 0x04 compares rs with rt and is resolved in the memory stage. If they are equal, the target is the branch's own address + 4 + (sign-extended imm << 2). The three instructions after the branch still complete. If they are unequal, the flow continues in sequence.
- R8: Register 0 always reads as zero, and writes to it are ignored.
- R9: There is no internal bypass. A write-back in cycle c is seen by a decode read in cycle c+1 or later, but not by a decode read in cycle c.
- R10: An unknown opcode, or opcode 0x00 with an unlisted funct, decodes to all-zero control and acts as a no-op. This includes the all-zero word.
- R11: dmem_re and dmem_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (the program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data address from the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| wb_we | output | 1 | Instruction in write-back writes a register |
| wb_reg | output | 5 | Destination register in write-back |
| wb_data | output | 32 | Value written in write-back |

## Verification
Each result has a fixed latency from the fetch cycle of its instruction. The fetch address moves one cycle after the branch decision. Memory strobes appear three cycles after fetch, and register write-backs appear four cycles after fetch. The bench runs a stage-by-stage behavioural model that advances on the same edge as the core. It compares imem_addr, the memory strobes and the write-back outputs on the falling edge that follows each rising edge, so every value is checked in the exact cycle it is due. It also records every non-zero write-back with its cycle number and compares the recorded list with the hand-computed results above, including the cycle numbers 5 to 9 for the five-instruction sequence.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluop_e;

  // execute-stage group
  typedef struct packed {
    logic   dst_rd;
    aluop_e alu_op;
    logic   use_imm;
  } ex_ctl_t;

  // memory-stage group
  typedef struct packed {
    logic rd_en;
    logic wr_en;
    logic branch;
  } mem_ctl_t;

  // write-back group
  typedef struct packed {
    logic reg_we;
    logic from_mem;
  } wb_ctl_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ex_ctl_t         ex_ctl,
  output mem_ctl_t        mem_ctl,
  output wb_ctl_t         wb_ctl
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic       fn_known;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];
  assign fn_known = (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) || (fn == FN_OR);

  always_comb begin
    ex_ctl  = '{dst_rd: 1'b0, alu_op: AOP_ADD, use_imm: 1'b0};
    mem_ctl = '0;
    wb_ctl  = '0;
    case (opc)
      OP_RTYPE: if (fn_known) begin
        ex_ctl.dst_rd = 1'b1;
        ex_ctl.alu_op = AOP_FUNCT;
        wb_ctl.reg_we = 1'b1;
      end
      OP_LOAD: begin
        ex_ctl.use_imm  = 1'b1;
        mem_ctl.rd_en   = 1'b1;
        wb_ctl.reg_we   = 1'b1;
        wb_ctl.from_mem = 1'b1;
      end
      OP_STORE: begin
        ex_ctl.use_imm = 1'b1;
        mem_ctl.wr_en  = 1'b1;
      end
      OP_BEQ: begin
        ex_ctl.alu_op  = AOP_SUB;
        mem_ctl.branch = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluop_e       op,
  input  logic [5:0]   funct,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      AOP_ADD: y = a + b;
      AOP_SUB: y = a - b;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  y = a + b;
          FN_SUB:  y = a - b;
          FN_AND:  y = a & b;
          FN_OR:   y = a | b;
          default: y = '0;
        endcase
      end
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int W         = 32,
  parameter int DEPTH     = 32,
  parameter int INIT_BIAS = 0,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= W'(i + INIT_BIAS);
    end else if (we && (wa != '0)) begin
      mem[wa] <= wd;
    end
  end

  // entry 0 is hard-wired to zero on read
  assign rdata_a = (ra == '0) ? '0 : mem[ra];
  assign rdata_b = (rb == '0) ? '0 : mem[rb];
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter logic [XLEN-1:0] START_ADDR   = '0,
  parameter int              RF_INIT_BIAS = 0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            wb_we,
  output logic [RIDX-1:0] wb_reg,
  output logic [XLEN-1:0] wb_data
);
  localparam int RF_DEPTH = 1 << RIDX;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc_q, pc_next;
  logic            take_branch;
  logic [XLEN-1:0] exmem_target;

  assign pc_next = take_branch ? exmem_target : pc_q + STEP;

  logic [XLEN-1:0] ifid_instr, ifid_pc4;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= START_ADDR;
      ifid_instr <= '0;
      ifid_pc4   <= '0;
    end else begin
      pc_q       <= pc_next;
      ifid_instr <= imem_rdata;
      ifid_pc4   <= pc_q + STEP;
    end
  end

  assign imem_addr = pc_q;

  // ---------------- decode ----------------
  ex_ctl_t         id_ex_ctl;
  mem_ctl_t        id_mem_ctl;
  wb_ctl_t         id_wb_ctl;
  logic [RIDX-1:0] id_rs, id_rt, id_rd;
  logic [XLEN-1:0] id_rs_val, id_rt_val, id_imm;

  logic            memwb_we;
  logic [RIDX-1:0] memwb_dest;
  logic [XLEN-1:0] memwb_value;

  assign id_rs  = ifid_instr[25:21];
  assign id_rt  = ifid_instr[20:16];
  assign id_rd  = ifid_instr[15:11];
  assign id_imm = {{(XLEN-16){ifid_instr[15]}}, ifid_instr[15:0]};

  pipe5_decode u_dec (
    .instr   (ifid_instr),
    .ex_ctl  (id_ex_ctl),
    .mem_ctl (id_mem_ctl),
    .wb_ctl  (id_wb_ctl)
  );

  pipe5_regfile #(
    .W         (XLEN),
    .DEPTH     (RF_DEPTH),
    .INIT_BIAS (RF_INIT_BIAS)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra      (id_rs),
    .rb      (id_rt),
    .rdata_a (id_rs_val),
    .rdata_b (id_rt_val),
    .we      (memwb_we),
    .wa      (memwb_dest),
    .wd      (memwb_value)
  );

  ex_ctl_t         idex_ex;
  mem_ctl_t        idex_mem;
  wb_ctl_t         idex_wb;
  logic [XLEN-1:0] idex_pc4, idex_a, idex_b, idex_imm;
  logic [RIDX-1:0] idex_rt, idex_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      idex_ex  <= '0;
      idex_mem <= '0;
      idex_wb  <= '0;
      idex_pc4 <= '0;
      idex_a   <= '0;
      idex_b   <= '0;
      idex_imm <= '0;
      idex_rt  <= '0;
      idex_rd  <= '0;
    end else begin
      idex_ex  <= id_ex_ctl;
      idex_mem <= id_mem_ctl;
      idex_wb  <= id_wb_ctl;
      idex_pc4 <= ifid_pc4;
      idex_a   <= id_rs_val;
      idex_b   <= id_rt_val;
      idex_imm <= id_imm;
      idex_rt  <= id_rt;
      idex_rd  <= id_rd;
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_opb, ex_y, ex_target;
  logic            ex_zero;
  logic [RIDX-1:0] ex_dest;

  assign ex_opb    = idex_ex.use_imm ? idex_imm : idex_b;
  assign ex_dest   = idex_ex.dst_rd ? idex_rd : idex_rt;
  assign ex_target = idex_pc4 + {idex_imm[XLEN-3:0], 2'b00};

  pipe5_alu #(.W(XLEN)) u_alu (
    .a     (idex_a),
    .b     (ex_opb),
    .op    (idex_ex.alu_op),
    .funct (idex_imm[5:0]),
    .y     (ex_y),
    .zero  (ex_zero)
  );

  mem_ctl_t        exmem_mem;
  wb_ctl_t         exmem_wb;
  logic [XLEN-1:0] exmem_alu, exmem_sdata;
  logic            exmem_zero;
  logic [RIDX-1:0] exmem_dest;

  always_ff @(posedge clk) begin
    if (rst) begin
      exmem_mem    <= '0;
      exmem_wb     <= '0;
      exmem_alu    <= '0;
      exmem_sdata  <= '0;
      exmem_zero   <= 1'b0;
      exmem_dest   <= '0;
      exmem_target <= '0;
    end else begin
      exmem_mem    <= idex_mem;
      exmem_wb     <= idex_wb;
      exmem_alu    <= ex_y;
      exmem_sdata  <= idex_b;
      exmem_zero   <= ex_zero;
      exmem_dest   <= ex_dest;
      exmem_target <= ex_target;
    end
  end

  // ---------------- memory ----------------
  logic [XLEN-1:0] mem_value;

  assign take_branch = exmem_mem.branch & exmem_zero;
  assign dmem_addr   = exmem_alu;
  assign dmem_wdata  = exmem_sdata;
  assign dmem_we     = exmem_mem.wr_en;
  assign dmem_re     = exmem_mem.rd_en;
  assign mem_value   = exmem_wb.from_mem ? dmem_rdata : exmem_alu;

  always_ff @(posedge clk) begin
    if (rst) begin
      memwb_we    <= 1'b0;
      memwb_dest  <= '0;
      memwb_value <= '0;
    end else begin
      memwb_we    <= exmem_wb.reg_we;
      memwb_dest  <= exmem_dest;
      memwb_value <= mem_value;
    end
  end

  // ---------------- write-back ----------------
  assign wb_we   = memwb_we;
  assign wb_reg  = memwb_dest;
  assign wb_data = memwb_value;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic        dmem_we,
  input logic        dmem_re,
  input logic        wb_we,
  input logic [4:0]  wb_reg,
  input logic        take_branch,
  input logic [31:0] branch_target,
  input logic [4:0]  id_rs,
  input logic [31:0] id_rs_val,
  input logic        ex_reg_we,
  input logic [4:0]  ex_dest
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dmem_we && !dmem_re && !wb_we));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (imem_addr == ($past(take_branch) ? $past(branch_target)
                                                      : $past(imem_addr) + 32'd4)));

  p_wb_lag_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(ex_reg_we, 2)) |-> (wb_we && wb_reg == $past(ex_dest, 2)));

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (id_rs == 5'd0) |-> (id_rs_val == 32'd0));

  p_mem_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .imem_addr     (imem_addr),
  .dmem_we       (dmem_we),
  .dmem_re       (dmem_re),
  .wb_we         (wb_we),
  .wb_reg        (wb_reg),
  .take_branch   (take_branch),
  .branch_target (exmem_target),
  .id_rs         (id_rs),
  .id_rs_val     (id_rs_val),
  .ex_reg_we     (idex_wb.reg_we),
  .ex_dest       (ex_dest)
);

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
  localparam logic [31:0] BASE = 32'd1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, wb_data;
  logic        dmem_we, dmem_re, wb_we;
  logic [4:0]  wb_reg;

  always #10ns clk = ~clk;

  pipe5_core #(.START_ADDR(BASE), .RF_INIT_BIAS(100)) dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
    .wb_we(wb_we), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  function automatic logic [31:0] fetch(input logic [31:0] a);
    logic [31:0] d;
    d = a - BASE;
    if (d[31:8] == 24'd0) return imem[d[7:2]];
    return 32'd0;
  endfunction

  assign imem_rdata = fetch(imem_addr);
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  // ---------------- behavioural stage model ----------------
  typedef struct {
    bit          wen;
    int          wreg;
    logic [31:0] wdata;
    bit          mre;
    bit          mwe;
    logic [31:0] addr;
    logic [31:0] sdata;
    bit          br;
    logic [31:0] target;
  } rec_t;

  logic [31:0] mregs [32];
  logic [31:0] mdmem [64];
  logic [31:0] mpc, f_instr, f_pc4;
  rec_t        s_ex, s_mem, s_wb;
  rec_t        blank = '{default: 0};

  function automatic rec_t mdecode(input logic [31:0] ins, input logic [31:0] pc4);
    rec_t r;
    logic [31:0] a, b, imm;
    r   = '{default: 0};
    a   = (ins[25:21] == 5'd0) ? 32'd0 : mregs[ins[25:21]];
    b   = (ins[20:16] == 5'd0) ? 32'd0 : mregs[ins[20:16]];
    imm = {{16{ins[15]}}, ins[15:0]};
    case (ins[31:26])
      6'h00: begin
        r.wen  = 1;
        r.wreg = int'(ins[15:11]);
        case (ins[5:0])
          6'h20: r.wdata = a + b;
          6'h22: r.wdata = a - b;
          6'h24: r.wdata = a & b;
          6'h25: r.wdata = a | b;
          default: r = '{default: 0};
        endcase
      end
      6'h23: begin r.wen = 1; r.wreg = int'(ins[20:16]); r.mre = 1; r.addr = a + imm; end
      6'h2B: begin r.mwe = 1; r.addr = a + imm; r.sdata = b; end
      6'h04: begin r.br = (a == b); r.target = pc4 + (imm << 2); end
      default: ;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    rec_t nr;
    logic [31:0] npc;
    if (rst) begin
      for (int i = 0; i < 32; i++) mregs[i] = 32'(i + 100);
      for (int i = 0; i < 64; i++) mdmem[i] = 32'd99;
      mpc = BASE; f_instr = 0; f_pc4 = 0;
      s_ex = blank; s_mem = blank; s_wb = blank;
    end else begin
      nr = mdecode(f_instr, f_pc4);            // decode reads before this edge's write-back
      if (s_mem.mre) s_mem.wdata = mdmem[s_mem.addr[7:2]];
      if (s_mem.mwe) mdmem[s_mem.addr[7:2]] = s_mem.sdata;
      if (s_wb.wen && s_wb.wreg != 0) mregs[s_wb.wreg] = s_wb.wdata;
      npc = s_mem.br ? s_mem.target : mpc + 32'd4;
      s_wb = s_mem; s_mem = s_ex; s_ex = nr;
      f_instr = fetch(mpc); f_pc4 = mpc + 32'd4; mpc = npc;
    end
  end

  int cyc;
  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  bit chk_on = 0;
  int ev_reg [$];
  logic [31:0] ev_val [$];
  int ev_cyc [$];

  always @(negedge clk) begin
    if (chk_on && !rst) begin
      chk(imem_addr == mpc, "R2 fetch address", imem_addr, mpc);
      chk(dmem_we == s_mem.mwe, "R6 store strobe", 32'(dmem_we), 32'(s_mem.mwe));
      if (s_mem.mwe) begin
        chk(dmem_addr == s_mem.addr, "R6 store address", dmem_addr, s_mem.addr);
        chk(dmem_wdata == s_mem.sdata, "R6 store data", dmem_wdata, s_mem.sdata);
      end
      chk(dmem_re == s_mem.mre, "R5 load strobe", 32'(dmem_re), 32'(s_mem.mre));
      if (s_mem.mre) chk(dmem_addr == s_mem.addr, "R5 load address", dmem_addr, s_mem.addr);
      chk(!(dmem_re && dmem_we), "R11 strobe exclusion", 32'(dmem_re & dmem_we), 0);
      chk(wb_we == s_wb.wen, "R3 R10 write-back enable", 32'(wb_we), 32'(s_wb.wen));
      if (s_wb.wen) begin
        chk(int'(wb_reg) == s_wb.wreg, "R4 write-back register", 32'(wb_reg), 32'(s_wb.wreg));
        chk(wb_data == s_wb.wdata, "R4 write-back value", wb_data, s_wb.wdata);
      end
      if (wb_we && wb_reg != 5'd0) begin
        ev_reg.push_back(int'(wb_reg));
        ev_val.push_back(wb_data);
        ev_cyc.push_back(cyc + 1);
      end
    end
  end

  // ---------------- programs ----------------
  function automatic logic [31:0] rt3(input int rd, input int rs, input int rt, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] it(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic load_prog(input int which);
    for (int i = 0; i < 64; i++) imem[i] = 32'd0;
    if (which == 1) begin
      imem[0] = it(6'h23, 29, 8, 4);
      imem[1] = rt3(2, 4, 5, 6'h22);
      imem[2] = rt3(9, 10, 11, 6'h24);
      imem[3] = rt3(16, 17, 18, 6'h25);
      imem[4] = rt3(13, 14, 0, 6'h20);
    end else begin
      imem[0]  = it(6'h2B, 1, 9, 8);          // store r9 -> 109
      imem[1]  = rt3(3, 4, 5, 6'h20);
      imem[4]  = it(6'h23, 1, 6, 8);          // load it back
      imem[5]  = it(6'h04, 7, 7, 4);          // taken, target index 10
      imem[6]  = rt3(10, 11, 12, 6'h22);
      imem[7]  = rt3(13, 14, 15, 6'h25);
      imem[8]  = rt3(16, 17, 18, 6'h24);
      imem[9]  = rt3(29, 1, 1, 6'h20);        // skipped
      imem[10] = it(6'h04, 1, 2, 5);          // not taken
      imem[11] = 32'hFC00_0000;               // unknown opcode
      imem[12] = rt3(0, 20, 21, 6'h20);       // write to register 0
      imem[13] = rt3(30, 1, 2, 6'h3F);        // unknown funct
      imem[14] = rt3(28, 1, 0, 6'h20);
      imem[16] = rt3(22, 0, 0, 6'h20);
      imem[17] = rt3(23, 6, 3, 6'h20);
      imem[18] = it(6'h23, 0, 24, 4);
      imem[19] = rt3(25, 1, 1, 6'h20);
      imem[22] = rt3(26, 25, 0, 6'h20);       // same cycle as write-back: old value
      imem[23] = rt3(27, 25, 0, 6'h20);       // one cycle later: new value
    end
  endtask

  task automatic run_prog(input int which, input int ncyc);
    @(negedge clk);
    chk_on = 0;
    rst = 1;
    load_prog(which);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 64; i++) dmem[i] = 32'd99;
    chk(imem_addr == BASE, "R1 fetch address in reset", imem_addr, BASE);
    chk(!wb_we && !dmem_we && !dmem_re, "R1 quiet in reset", 32'({wb_we, dmem_we, dmem_re}), 0);
    ev_reg.delete(); ev_val.delete(); ev_cyc.delete();
    rst = 0;
    chk_on = 1;
    repeat (ncyc) @(negedge clk);
    chk_on = 0;
  endtask

  int          p1_reg [5] = '{8, 2, 9, 16, 13};
  logic [31:0] p1_val [5] = '{32'd99, 32'hFFFF_FFFF, 32'd110, 32'd119, 32'd114};
  int          p2_reg [12] = '{3, 6, 10, 13, 16, 28, 22, 23, 24, 25, 26, 27};
  logic [31:0] p2_val [12] = '{32'd209, 32'd109, 32'hFFFF_FFFF, 32'd115, 32'd116, 32'd101,
                               32'd0, 32'd318, 32'd99, 32'd202, 32'd125, 32'd202};

  initial begin
    run_prog(1, 14);
    // R3: fixed results in cycles 5..9
    chk(ev_reg.size() == 5, "R3 write-back count", 32'(ev_reg.size()), 5);
    for (int i = 0; i < 5 && i < ev_reg.size(); i++) begin
      chk(ev_reg[i] == p1_reg[i], "R3 scenario register", 32'(ev_reg[i]), 32'(p1_reg[i]));
      chk(ev_val[i] == p1_val[i], "R3 scenario value", ev_val[i], p1_val[i]);
      chk(ev_cyc[i] == 5 + i, "R3 scenario cycle", 32'(ev_cyc[i]), 32'(5 + i));
    end

    run_prog(2, 40);
    // R5 R6 R7 R8 R9 R10: store/load, taken and untaken branch, register 0, no bypass
    chk(ev_reg.size() == 12, "R7 R10 write-back count", 32'(ev_reg.size()), 12);
    for (int i = 0; i < 12 && i < ev_reg.size(); i++) begin
      chk(ev_reg[i] == p2_reg[i], "R7 R8 R9 sequence register", 32'(ev_reg[i]), 32'(p2_reg[i]));
      chk(ev_val[i] == p2_val[i], "R5 R8 R9 sequence value", ev_val[i], p2_val[i]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule